// File: doc/BRIEF.md
# Receive Frame Address and Type Filter

This block watches the first sixteen bytes of every received wireless MAC header and decides whether the frame is handed to the host. The bytes come in as a stream qualified by a valid strobe, and a start strobe marks the first byte of each frame. The block counts the bytes, keeps the first frame-control byte, the receiver address and the transmitter address, and then classifies the frame. It decodes the frame type and subtype, compares the addresses with the station's own address and the configured network identifier (BSSID), and looks for broadcast and multicast patterns.

A small write-only configuration port loads the own address, the BSSID and a 14-bit category mask. Each mask bit enables one class of frame, and a frame passes when any enabled class matches it. One cycle after the last byte of the transmitter address, the block emits a one-cycle decision strobe together with the pass bit. Frames that stop early produce no decision.

Top module: `rx_frame_filter`

## Requirements
- R1: Header bytes arrive in this order: byte 0 carries frame control, byte 2 onward the duration field, bytes 4..9 the receiver address and bytes 10..15 the transmitter address. Cycles with the valid strobe low are skipped. `dec_valid_o` pulses for exactly one cycle: the cycle after the clock edge that accepts byte 15.
- R2: A start strobe during a frame restarts the count, so the cut-short frame gets no decision. Bytes that arrive without a start strobe after a decision, or out of reset, are ignored until the next start.
- R3: Configuration writes use select 0 for own address bytes 0..3 (byte 0 in bits 7:0), 1 for own address bytes 4..5 in bits 15:0 (bits 31:16 ignored), 2 and 3 for the BSSID in the same layout, and 4 for the mask in bits 13:0.
- R4: Mask bit 9 passes a frame whose receiver address equals the own address.
- R5: Mask bit 10 passes a receiver address of all ones. Mask bit 11 passes a receiver address of all zeros.
- R6: Mask bit 1 passes a receiver address starting with bytes 01,00,5E or with bytes 33,33.
- R7: Type is frame-control bits 3:2 and subtype is bits 7:4. Mask bit 4 passes beacons (type 0, subtype 8) and probe responses (type 0, subtype 5) from any sender. Mask bit 12 passes a beacon only when its transmitter address equals the BSSID.
- R8: Mask bit 5 passes any control frame (type 1). Mask bit 7 passes PS-Poll (type 1, subtype 10). Mask bit 8 passes probe requests (type 0, subtype 4).
- R9: Mask bit 6 passes a frame whose transmitter address differs from the BSSID.
- R10: Mask bit 13 passes every frame, whatever the other bits hold.
- R11: Mask bits 0, 2 and 3 have no effect. After reset every register is zero, no decision is pending, and with a zero mask every frame is dropped.
- R12: A frame passes when at least one enabled category matches it. `dec_pass_o` is low whenever `dec_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Configuration register select |
| cfg_wdata_i | input | 32 | Configuration write data |
| sof_i | input | 1 | Marks the current byte as byte 0 of a frame |
| byte_valid_i | input | 1 | Byte stream qualifier |
| byte_i | input | 8 | Header byte |
| dec_valid_o | output | 1 | One-cycle decision strobe |
| dec_pass_o | output | 1 | Pass (1) or drop (0), valid with the strobe |

## Verification
A table of frames pairs each mask category with a frame that should match it and a near miss that should not. The near misses include a multicast prefix with one wrong byte, a beacon from a foreign BSSID, a data frame from the own BSSID and a probe response offered to the probe-request bit. Together these separate the address compares from the type decode. Directed tests cover the reset default, a frame truncated by a new start, stray bytes after a decision, byte streams with valid gaps, and ignored upper bits in the configuration words. They also check that no decision appears one cycle early.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int BYTE_W     = 8;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = ADDR_BYTES * BYTE_W;
  localparam int CFG_DW     = 32;
  localparam int RA_BASE    = 4;
  localparam int TA_BASE    = RA_BASE + ADDR_BYTES;
  localparam int HDR_LAST   = TA_BASE + ADDR_BYTES - 1;
  localparam int CNT_W      = $clog2(HDR_LAST + 2);
  localparam int FLAG_W     = 14;

  // mask bit positions
  localparam int F_MCAST   = 1;
  localparam int F_BCN_ANY = 4;
  localparam int F_CTRL    = 5;
  localparam int F_OBSS    = 6;
  localparam int F_PSPOLL  = 7;
  localparam int F_PREQ    = 8;
  localparam int F_UCAST   = 9;
  localparam int F_BC_ONES = 10;
  localparam int F_BC_ZERO = 11;
  localparam int F_BCN_OWN = 12;
  localparam int F_MONITOR = 13;

  typedef enum logic [2:0] {
    CFG_OWN_LO = 3'd0,
    CFG_OWN_HI = 3'd1,
    CFG_BSS_LO = 3'd2,
    CFG_BSS_HI = 3'd3,
    CFG_FLAGS  = 3'd4
  } cfg_sel_e;

  localparam logic [1:0] FT_MGMT   = 2'd0;
  localparam logic [1:0] FT_CTRL   = 2'd1;
  localparam logic [3:0] ST_PREQ   = 4'd4;
  localparam logic [3:0] ST_PRSP   = 4'd5;
  localparam logic [3:0] ST_BEACON = 4'd8;
  localparam logic [3:0] ST_PSPOLL = 4'd10;
endpackage

// File: rtl/rxf_cfg.sv
module rxf_cfg
  import rxf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        sel_i,
  input  logic [CFG_DW-1:0] wdata_i,
  output logic [ADDR_W-1:0] own_o,
  output logic [ADDR_W-1:0] bss_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam int N_ADDR = 2;
  localparam int LO_W   = CFG_DW;
  localparam int HI_W   = ADDR_W - LO_W;

  logic [N_ADDR-1:0][ADDR_W-1:0] addr_q;
  logic [FLAG_W-1:0]             flags_q;

  for (genvar g = 0; g < N_ADDR; g++) begin : g_addr
    localparam logic [2:0] SEL_LO = 3'(2 * g);
    localparam logic [2:0] SEL_HI = 3'(2 * g + 1);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_q[g] <= '0;
      end else if (we_i) begin
        if (sel_i == SEL_LO) addr_q[g][LO_W-1:0]      <= wdata_i;
        if (sel_i == SEL_HI) addr_q[g][ADDR_W-1:LO_W] <= wdata_i[HI_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        flags_q <= '0;
    else if (we_i && sel_i == CFG_FLAGS) flags_q <= wdata_i[FLAG_W-1:0];
  end

  assign own_o   = addr_q[0];
  assign bss_o   = addr_q[1];
  assign flags_o = flags_q;

  AST_FLAG_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == CFG_FLAGS) |=> flags_o == $past(wdata_i[FLAG_W-1:0])); // R3
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && sel_i == CFG_FLAGS) |=> $stable(flags_o)); // R3
endmodule

// File: rtl/rxf_hdr_capture.sv
module rxf_hdr_capture
  import rxf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [BYTE_W-1:0] fc0_o,
  output logic [ADDR_W-1:0] ra_o,
  output logic [ADDR_W-1:0] ta_o,
  output logic              done_o
);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(HDR_LAST);

  logic [CNT_W-1:0]                   cnt_q;
  logic                               active_q;
  logic                               done_q;
  logic [BYTE_W-1:0]                  fc0_q;
  logic [ADDR_BYTES-1:0][BYTE_W-1:0]  ra_q;
  logic [ADDR_BYTES-1:0][BYTE_W-1:0]  ta_q;
  logic                               take;

  // a byte belongs to the running frame only if it is not a new start
  assign take = valid_i && active_q && !sof_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      fc0_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (valid_i && sof_i) begin
        cnt_q    <= CNT_W'(1);
        active_q <= 1'b1;
        fc0_q    <= byte_i;
      end else if (take) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST_C) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_byte
    localparam logic [CNT_W-1:0] RA_C = CNT_W'(RA_BASE + g);
    localparam logic [CNT_W-1:0] TA_C = CNT_W'(TA_BASE + g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ra_q[g] <= '0;
        ta_q[g] <= '0;
      end else if (take) begin
        if (cnt_q == RA_C) ra_q[g] <= byte_i;
        if (cnt_q == TA_C) ta_q[g] <= byte_i;
      end
    end
  end

  assign fc0_o  = fc0_q;
  assign ra_o   = ra_q;
  assign ta_o   = ta_q;
  assign done_o = done_q;

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> cnt_q <= LAST_C); // R1
  AST_DEC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R1
  AST_DEC_AFTER_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(valid_i) && !$past(sof_i)); // R1
  AST_IDLE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && !(valid_i && sof_i)) |=> !done_o); // R2
endmodule

// File: rtl/rxf_accept.sv
module rxf_accept
  import rxf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [ADDR_W-1:0] own_i,
  input  logic [ADDR_W-1:0] bss_i,
  input  logic [BYTE_W-1:0] fc0_i,
  input  logic [ADDR_W-1:0] ra_i,
  input  logic [ADDR_W-1:0] ta_i,
  output logic              pass_o
);
  logic [1:0]        ftype;
  logic [3:0]        fsub;
  logic              is_mgmt, is_ctrl, is_beacon, is_prsp, is_preq, is_pspoll;
  logic              ra_own, ra_ones, ra_zero, ra_mcast, ta_bss;
  logic [FLAG_W-1:0] hit;
  logic              unused_bits;

  assign ftype = fc0_i[3:2];
  assign fsub  = fc0_i[7:4];

  assign is_mgmt   = ftype == FT_MGMT;
  assign is_ctrl   = ftype == FT_CTRL;
  assign is_beacon = is_mgmt && fsub == ST_BEACON;
  assign is_prsp   = is_mgmt && fsub == ST_PRSP;
  assign is_preq   = is_mgmt && fsub == ST_PREQ;
  assign is_pspoll = is_ctrl && fsub == ST_PSPOLL;

  assign ra_own   = ra_i == own_i;
  assign ra_ones  = &ra_i;
  assign ra_zero  = ~|ra_i;
  // byte 0 occupies the low bits, so the prefix reads right to left
  assign ra_mcast = (ra_i[23:0] == 24'h5E0001) || (ra_i[15:0] == 16'h3333);
  assign ta_bss   = ta_i == bss_i;

  always_comb begin
    hit            = '0;
    hit[F_MCAST]   = ra_mcast;
    hit[F_BCN_ANY] = is_beacon || is_prsp;
    hit[F_CTRL]    = is_ctrl;
    hit[F_OBSS]    = !ta_bss;
    hit[F_PSPOLL]  = is_pspoll;
    hit[F_PREQ]    = is_preq;
    hit[F_UCAST]   = ra_own;
    hit[F_BC_ONES] = ra_ones;
    hit[F_BC_ZERO] = ra_zero;
    hit[F_BCN_OWN] = is_beacon && ta_bss;
    hit[F_MONITOR] = 1'b1;
  end

  assign unused_bits = ^{flags_i[0], flags_i[3:2], fc0_i[1:0]};
  assign pass_o      = valid_i && |(hit & flags_i);

  AST_MONITOR_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && flags_i[F_MONITOR]) |-> pass_o); // R10
  AST_ZERO_MASK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && flags_i == '0) |-> !pass_o); // R11
  AST_PASS_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !pass_o); // R12
endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter
  import rxf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_sel_i,
  input  logic [CFG_DW-1:0] cfg_wdata_i,
  input  logic              sof_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              dec_valid_o,
  output logic              dec_pass_o
);
  logic [ADDR_W-1:0] own, bss, ra, ta;
  logic [FLAG_W-1:0] flags;
  logic [BYTE_W-1:0] fc0;
  logic              done;

  rxf_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .own_o   (own),
    .bss_o   (bss),
    .flags_o (flags)
  );

  rxf_hdr_capture u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sof_i   (sof_i),
    .valid_i (byte_valid_i),
    .byte_i  (byte_i),
    .fc0_o   (fc0),
    .ra_o    (ra),
    .ta_o    (ta),
    .done_o  (done)
  );

  rxf_accept u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (done),
    .flags_i (flags),
    .own_i   (own),
    .bss_i   (bss),
    .fc0_i   (fc0),
    .ra_i    (ra),
    .ta_i    (ta),
    .pass_o  (dec_pass_o)
  );

  assign dec_valid_o = done;

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !dec_valid_o); // R11
endmodule

// File: tb/sim_rx_frame_filter.sv
module sim_rx_frame_filter;
  localparam int CLK_PERIOD = 10;

  localparam logic [47:0] OWN   = 48'h554433221102;
  localparam logic [47:0] BSS   = 48'hbbaa99887766;
  localparam logic [47:0] OTH   = 48'h0a0b0c0d0e02;
  localparam logic [47:0] ONES  = 48'hffffffffffff;
  localparam logic [47:0] ZERO  = 48'h0;
  localparam logic [7:0]  DATA  = 8'h08;
  localparam logic [7:0]  BCN   = 8'h80;
  localparam logic [7:0]  PRSP  = 8'h50;
  localparam logic [7:0]  PREQ  = 8'h40;
  localparam logic [7:0]  PSPL  = 8'hA4;
  localparam logic [7:0]  ACKF  = 8'hD4;

  typedef struct packed {
    logic [3:0]  req;
    logic [13:0] flags;
    logic [7:0]  fc0;
    logic [47:0] ra;
    logic [47:0] ta;
    logic        exp;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    '{4'd4,  14'h0200, DATA, OWN,  BSS, 1'b1},            // R4
    '{4'd4,  14'h0200, DATA, OTH,  BSS, 1'b0},            // R4
    '{4'd5,  14'h0400, DATA, ONES, BSS, 1'b1},            // R5
    '{4'd5,  14'h0400, DATA, ZERO, BSS, 1'b0},            // R5
    '{4'd5,  14'h0800, DATA, ZERO, BSS, 1'b1},            // R5
    '{4'd6,  14'h0002, DATA, 48'h0302015e0001, BSS, 1'b1}, // R6
    '{4'd6,  14'h0002, DATA, 48'h010000003333, BSS, 1'b1}, // R6
    '{4'd6,  14'h0002, DATA, 48'h0302015f0001, BSS, 1'b0}, // R6
    '{4'd7,  14'h0010, BCN,  ONES, OTH, 1'b1},            // R7
    '{4'd7,  14'h0010, PRSP, OTH,  OTH, 1'b1},            // R7
    '{4'd7,  14'h1000, BCN,  ONES, BSS, 1'b1},            // R7
    '{4'd7,  14'h1000, BCN,  ONES, OTH, 1'b0},            // R7
    '{4'd7,  14'h1000, DATA, ONES, BSS, 1'b0},            // R7
    '{4'd8,  14'h0020, ACKF, OTH,  BSS, 1'b1},            // R8
    '{4'd8,  14'h0020, DATA, OTH,  BSS, 1'b0},            // R8
    '{4'd8,  14'h0080, PSPL, OTH,  BSS, 1'b1},            // R8
    '{4'd8,  14'h0100, PREQ, ONES, OTH, 1'b1},            // R8
    '{4'd8,  14'h0100, PRSP, ONES, OTH, 1'b0},            // R8
    '{4'd9,  14'h0040, DATA, OTH,  OTH, 1'b1},            // R9
    '{4'd9,  14'h0040, DATA, OTH,  BSS, 1'b0},            // R9
    '{4'd10, 14'h2000, DATA, OTH,  BSS, 1'b1},            // R10
    '{4'd11, 14'h000D, DATA, OTH,  BSS, 1'b0},            // R11
    '{4'd11, 14'h0000, DATA, OWN,  OTH, 1'b0},            // R11
    '{4'd12, 14'h0600, DATA, ONES, BSS, 1'b1}             // R12
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        sof = 1'b0;
  logic        bvalid = 1'b0;
  logic [7:0]  bdata = '0;
  logic        dec_valid, dec_pass;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_frame_filter u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cfg_we_i     (cfg_we),
    .cfg_sel_i    (cfg_sel),
    .cfg_wdata_i  (cfg_wdata),
    .sof_i        (sof),
    .byte_valid_i (bvalid),
    .byte_i       (bdata),
    .dec_valid_o  (dec_valid),
    .dec_pass_o   (dec_pass)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(logic [2:0] sel, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drives header bytes idx 0..15; gap inserts an idle cycle after each byte
  task automatic send_hdr(logic [7:0] fc0, logic [47:0] ra, logic [47:0] ta, bit gap,
                          output bit early_seen);
    early_seen = 1'b0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (dec_valid) early_seen = 1'b1;
      sof = (i == 0);
      bvalid = 1'b1;
      if (i == 0)       bdata = fc0;
      else if (i < 4)   bdata = 8'(i * 17);
      else if (i < 10)  bdata = ra[(i-4)*8 +: 8];
      else              bdata = ta[(i-10)*8 +: 8];
      if (gap && i != 15) begin
        @(negedge clk);
        if (dec_valid) early_seen = 1'b1;
        sof = 1'b0; bvalid = 1'b0; bdata = 8'hEE;
      end
    end
    @(negedge clk);
    sof = 1'b0; bvalid = 1'b0;
  endtask

  task automatic set_addrs();
    cfg_write(3'd0, OWN[31:0]);
    cfg_write(3'd1, {16'h0, OWN[47:32]});
    cfg_write(3'd2, BSS[31:0]);
    cfg_write(3'd3, {16'h0, BSS[47:32]});
  endtask

  initial begin
    bit early;
    int pulses;
    repeat (3) @(negedge clk);
    check("R11", {30'd0, dec_valid, dec_pass}, 32'd0, "outputs in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", {31'd0, dec_valid}, 32'd0, "no decision after reset");

    // zero mask after reset: a broadcast data frame is dropped
    send_hdr(DATA, ONES, OTH, 1'b0, early);
    check("R11", {30'd0, dec_valid, dec_pass}, 32'h2, "reset mask drops all");
    check("R1", {31'd0, early}, 32'd0, "no decision before last byte");
    @(negedge clk);
    check("R1", {31'd0, dec_valid}, 32'd0, "decision is a single pulse");

    set_addrs();

    for (int v = 0; v < NV; v++) begin
      cfg_write(3'd4, {18'h0, TBL[v].flags});
      send_hdr(TBL[v].fc0, TBL[v].ra, TBL[v].ta, 1'b0, early);
      n_tests++;
      if (dec_valid !== 1'b1 || dec_pass !== TBL[v].exp) begin
        n_fail++;
        $display("FAIL R%0d vector %0d: actual valid=%b pass=%b expected valid=1 pass=%b",
                 TBL[v].req, v, dec_valid, dec_pass, TBL[v].exp);
      end
    end

    // R1: valid gaps between bytes
    cfg_write(3'd4, 32'h0200);
    send_hdr(DATA, OWN, BSS, 1'b1, early);
    check("R1", {30'd0, dec_valid, dec_pass}, 32'h3, "gapped stream decision");
    check("R1", {31'd0, early}, 32'd0, "gapped stream no early decision");

    // R3: upper bits of high address word ignored
    cfg_write(3'd1, {16'hFFFF, OWN[47:32]});
    send_hdr(DATA, OWN, BSS, 1'b0, early);
    check("R3", {30'd0, dec_valid, dec_pass}, 32'h3, "high word upper bits ignored");
    // R3: own address byte order; flip byte 5 only
    cfg_write(3'd1, {16'h0, 8'h56, OWN[39:32]});
    send_hdr(DATA, OWN, BSS, 1'b0, early);
    check("R3", {30'd0, dec_valid, dec_pass}, 32'h2, "changed byte 5 breaks match");
    cfg_write(3'd1, {16'h0, OWN[47:32]});

    // R2: truncated frame then full frame; count pulses
    cfg_write(3'd4, 32'h2000);
    pulses = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      sof = (i == 0); bvalid = 1'b1; bdata = 8'h08;
    end
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      sof = 1'b0; bvalid = 1'b0;
      if (dec_valid) pulses++;
    end
    check("R2", 32'(pulses), 32'd0, "truncated frame no decision");
    // restart mid-frame: 12 bytes, then a new start with a full header
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      sof = (i == 0); bvalid = 1'b1; bdata = 8'h00;
      if (dec_valid) pulses++;
    end
    send_hdr(DATA, OTH, BSS, 1'b0, early);
    check("R2", {31'd0, early}, 32'd0, "restarted frame silent before end");
    check("R2", {30'd0, dec_valid, dec_pass}, 32'h3, "restarted frame decided");
    // stray bytes after decision ignored
    pulses = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      sof = 1'b0; bvalid = 1'b1; bdata = 8'(i);
      if (dec_valid && i > 0) pulses++;
    end
    @(negedge clk);
    bvalid = 1'b0;
    if (dec_valid) pulses++;
    @(negedge clk);
    if (dec_valid) pulses++;
    check("R2", 32'(pulses), 32'd0, "stray bytes after decision");

    // R12: outputs low between decisions
    check("R12", {30'd0, dec_valid, dec_pass}, 32'd0, "pass low without strobe");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule